// File: doc/BRIEF.md
# Prefetching Read Retry Controller

This controller serves reads that must cross from a fast primary bus to a slower secondary bus without holding the primary bus while the slow side works. When a read first arrives, the controller records its identity (address, word count, transfer type and requester ID). It starts one burst fetch on the secondary side and answers the requester with a retry. The fetched words land in a 32-bit-wide buffer. When the same requester issues the identical read again, the controller accepts it and streams the buffered words back on consecutive cycles. The buffer is then flushed and the controller goes back to idle.

Only one prefetch exists at a time. Every other read is retried until the current one has been reclaimed or dropped. This includes a read that matches the captured one but arrives before the fill is complete. A saturating watchdog starts when a read is captured. If the data is complete and the watchdog has run out before the matching read returns, the data is discarded and a one-cycle event tells the interrupt logic that a prefetch was never reclaimed. A reset of the secondary side while the fill is in flight throws away the partial data. The primary requester's next retry then starts a fresh fetch.

Top module: `prefetch_retry_ctrl`

## Requirements
- R1: After `rst`, the controller is idle: `fetchReq`, `respRetry`, `respAccept`, `rdValid`, `rdLast` and `pfTimeout` are all 0.
- R2: A read (`reqValid`=1) taken while idle is answered with `respRetry`=1 in the following cycle. In that same cycle `fetchReq` rises with `fetchAddr`/`fetchLen` equal to the captured address and length. `fetchReq` then holds, with stable fields, until the cycle in which `fetchAck` is 1.
- R3: While the fill runs, each cycle with `secDataValid`=1 stores `secData` into the next buffer word, in arrival order. Any read during the fill, including an identical one, gets `respRetry`.
- R4: Only one prefetch is outstanding. A read that arrives while a prefetch is being filled, held or drained gets `respRetry` and does not raise `fetchReq` again.
- R5: A read is equivalent only if `reqAddr`, `reqLen`, `reqType` and `reqMid` all equal the captured values. A difference in any one field gives `respRetry`.
- R6: An equivalent read taken once the buffer holds all `reqLen`+1 words gets `respAccept`=1 in the following cycle. From that cycle on, `rdValid` is 1 for exactly `reqLen`+1 consecutive cycles, carrying the words in fill order. `rdLast` is 1 only on the final word, after which the controller is idle.
- R7: The watchdog counts cycles from the capture edge and saturates at 2^TMO_W−1. With the buffer full and no equivalent read, the controller drops the data at the 2^TMO_W-th edge after capture. `pfTimeout` is then 1 for exactly one cycle, and a later equivalent read is treated as new: it gets a retry and a fresh fetch.
- R8: With `secRst`=1 during the fill, the partial data is discarded and the controller goes idle. The next read starts a new fetch, and only data from that new fetch is returned.
- R9: Buffer depth is 16×(WIDEST_W/32) words, and `reqLen` (word count minus one) is log2 of that wide. The full 16-word burst of the default configuration fills and drains completely.
- R10: Each cycle with `reqValid`=1 is answered in the next cycle by exactly one of `respRetry`/`respAccept`. Neither is raised without a request in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (both sides share its edges) |
| rst | input | 1 | Synchronous reset, active high |
| secRst | input | 1 | Secondary-side reset; discards an in-flight fill |
| reqValid | input | 1 | Primary read request strobe, one cycle per request |
| reqAddr | input | ADDR_W | Request address |
| reqLen | input | LEN_W | Words to read minus one |
| reqType | input | 3 | Transfer type code |
| reqMid | input | MID_W | Requesting master ID |
| respRetry | output | 1 | Retry answer for the request of the previous cycle |
| respAccept | output | 1 | Accept answer; read data starts in the same cycle |
| rdValid | output | 1 | Read word valid |
| rdData | output | 32 | Read word |
| rdLast | output | 1 | Final read word |
| fetchReq | output | 1 | Secondary burst fetch request |
| fetchAddr | output | ADDR_W | Fetch start address |
| fetchLen | output | LEN_W | Fetch words minus one |
| fetchAck | input | 1 | Secondary master took the fetch request |
| secDataValid | input | 1 | Fetched word valid |
| secData | input | 32 | Fetched word |
| pfTimeout | output | 1 | One-cycle event: prefetched data dropped unreclaimed |

## Verification
Some rules hold on every cycle and are checked by the assertions. Each request gets exactly one answer, and no answer comes without a request. An accept coincides with the first read word, a final word closes the stream, and the fetch request is held with steady fields until acknowledged. No fetch is raised while draining, and the timeout event lasts only one cycle. Other behaviour can only be shown by the bench scenarios: the order of the returned data, the exact field-by-field match rule, the cycle on which the watchdog fires, and the fact that partial data from a secondary reset never reaches the primary side.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READY,
    ST_DRAIN
  } prcState_t;

  typedef struct packed {
    logic capture;
    logic bufWrite;
    logic bufRead;
    logic flush;
    logic tmoRun;
  } prcCtl_t;

endpackage

// File: rtl/prc_datapath.sv
module prc_datapath
  import prc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 3,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 4,
  parameter int TMO_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  prcCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [2:0]        reqType,
  input  logic [MID_W-1:0]  reqMid,
  input  logic [31:0]       secData,
  output logic              match,
  output logic              fillLast,
  output logic              drainLast,
  output logic              tmoExpired,
  output logic [31:0]       rdData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [LEN_W-1:0]  fetchLen
);

  logic [31:0]       wordMem [DEPTH];
  logic [LEN_W-1:0]  wrPtr, rdPtr;
  logic [ADDR_W-1:0] capAddr;
  logic [LEN_W-1:0]  capLen;
  logic [2:0]        capType;
  logic [MID_W-1:0]  capMid;
  logic [TMO_W-1:0]  tmoCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      capAddr <= '0;
      capLen  <= '0;
      capType <= '0;
      capMid  <= '0;
    end else if (ctl.capture) begin
      capAddr <= reqAddr;
      capLen  <= reqLen;
      capType <= reqType;
      capMid  <= reqMid;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.bufWrite) wordMem[wrPtr] <= secData;
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.capture || ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.bufWrite) wrPtr <= wrPtr + 1'b1;
      if (ctl.bufRead)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.capture) tmoCnt <= '0;
    else if (ctl.tmoRun && !tmoExpired) tmoCnt <= tmoCnt + 1'b1;
  end

  assign match      = (reqAddr == capAddr) && (reqLen == capLen) &&
                      (reqType == capType) && (reqMid == capMid);
  assign fillLast   = (wrPtr == capLen);
  assign drainLast  = (rdPtr == capLen);
  assign tmoExpired = &tmoCnt;
  assign rdData     = wordMem[rdPtr];
  assign fetchAddr  = capAddr;
  assign fetchLen   = capLen;

endmodule

// File: rtl/prc_control.sv
module prc_control
  import prc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    secRst,
  input  logic    reqValid,
  input  logic    match,
  input  logic    fillLast,
  input  logic    drainLast,
  input  logic    tmoExpired,
  input  logic    fetchAck,
  input  logic    secDataValid,
  output prcCtl_t ctl,
  output logic    fetchReq,
  output logic    respRetry,
  output logic    respAccept,
  output logic    rdValid,
  output logic    rdLast,
  output logic    pfTimeout
);

  prcState_t state, stateNext;
  logic      issued;
  logic      retryNext, acceptNext, tmoNext;

  always_comb begin
    ctl        = '0;
    stateNext  = state;
    retryNext  = reqValid;
    acceptNext = 1'b0;
    tmoNext    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          stateNext   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        ctl.tmoRun = 1'b1;
        if (secRst) begin
          ctl.flush = 1'b1;
          stateNext = ST_IDLE;
        end else if (secDataValid) begin
          ctl.bufWrite = 1'b1;
          if (fillLast) stateNext = ST_READY;
        end
      end
      ST_READY: begin
        ctl.tmoRun = 1'b1;
        if (reqValid && match) begin
          retryNext  = 1'b0;
          acceptNext = 1'b1;
          stateNext  = ST_DRAIN;
        end else if (tmoExpired) begin
          ctl.flush = 1'b1;
          tmoNext   = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        ctl.bufRead = 1'b1;
        if (drainLast) begin
          ctl.flush = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      issued     <= 1'b0;
      respRetry  <= 1'b0;
      respAccept <= 1'b0;
      pfTimeout  <= 1'b0;
    end else begin
      state      <= stateNext;
      respRetry  <= retryNext;
      respAccept <= acceptNext;
      pfTimeout  <= tmoNext;
      if (ctl.capture) issued <= 1'b0;
      else if (fetchReq && fetchAck) issued <= 1'b1;
    end
  end

  assign fetchReq = (state == ST_FETCH) && !issued;
  assign rdValid  = (state == ST_DRAIN);
  assign rdLast   = rdValid && drainLast;

endmodule

// File: rtl/prefetch_retry_ctrl.sv
module prefetch_retry_ctrl
  import prc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MID_W    = 3,
  parameter int WIDEST_W = 32,
  parameter int TMO_W    = 10,
  localparam int DEPTH   = 16 * (WIDEST_W / 32),
  localparam int LEN_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              secRst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [2:0]        reqType,
  input  logic [MID_W-1:0]  reqMid,
  output logic              respRetry,
  output logic              respAccept,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              rdLast,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [LEN_W-1:0]  fetchLen,
  input  logic              fetchAck,
  input  logic              secDataValid,
  input  logic [31:0]       secData,
  output logic              pfTimeout
);

  prcCtl_t ctl;
  logic    match, fillLast, drainLast, tmoExpired;

  prc_datapath #(
    .ADDR_W(ADDR_W), .MID_W(MID_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .TMO_W(TMO_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqType(reqType), .reqMid(reqMid),
    .secData(secData), .match(match), .fillLast(fillLast),
    .drainLast(drainLast), .tmoExpired(tmoExpired), .rdData(rdData),
    .fetchAddr(fetchAddr), .fetchLen(fetchLen)
  );

  prc_control u_ctl (
    .clk(clk), .rst(rst), .secRst(secRst), .reqValid(reqValid),
    .match(match), .fillLast(fillLast), .drainLast(drainLast),
    .tmoExpired(tmoExpired), .fetchAck(fetchAck), .secDataValid(secDataValid),
    .ctl(ctl), .fetchReq(fetchReq), .respRetry(respRetry),
    .respAccept(respAccept), .rdValid(rdValid), .rdLast(rdLast),
    .pfTimeout(pfTimeout)
  );

endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              respRetry,
  input logic              respAccept,
  input logic              rdValid,
  input logic              rdLast,
  input logic              fetchReq,
  input logic              fetchAck,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              pfTimeout
);

  p_one_answer_r10: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> (respRetry ^ respAccept));

  p_no_spurious_answer_r10: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!respRetry && !respAccept));

  p_accept_with_data_r6: assert property (@(posedge clk) disable iff (rst)
    respAccept |-> rdValid);

  p_last_closes_r6: assert property (@(posedge clk) disable iff (rst)
    (rdValid && rdLast) |=> !rdValid);

  p_fetch_held_r2: assert property (@(posedge clk) disable iff (rst)
    (fetchReq && !fetchAck) |=> (fetchReq && $stable(fetchAddr)));

  p_single_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> !fetchReq);

  p_timeout_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pfTimeout |=> !pfTimeout);

endmodule

bind prefetch_retry_ctrl prc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .respRetry(respRetry),
  .respAccept(respAccept), .rdValid(rdValid), .rdLast(rdLast),
  .fetchReq(fetchReq), .fetchAck(fetchAck), .fetchAddr(fetchAddr),
  .pfTimeout(pfTimeout)
);

// File: tb/tb_prefetch_retry_ctrl.sv
`timescale 1ns/1ps
module tb_prefetch_retry_ctrl;

  localparam int ADDR_W = 32;
  localparam int MID_W  = 3;
  localparam int TMO_W  = 6;
  localparam int LEN_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, secRst = 1'b0, reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic [2:0]        reqType = '0;
  logic [MID_W-1:0]  reqMid = '0;
  logic respRetry, respAccept, rdValid, rdLast, fetchReq, pfTimeout;
  logic [31:0] rdData;
  logic [ADDR_W-1:0] fetchAddr;
  logic [LEN_W-1:0]  fetchLen;
  logic fetchAck = 1'b0, secDataValid = 1'b0;
  logic [31:0] secData = '0;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  prefetch_retry_ctrl #(.ADDR_W(ADDR_W), .MID_W(MID_W), .WIDEST_W(32), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst(rst), .secRst(secRst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqType(reqType), .reqMid(reqMid), .respRetry(respRetry),
    .respAccept(respAccept), .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchLen(fetchLen),
    .fetchAck(fetchAck), .secDataValid(secDataValid), .secData(secData),
    .pfTimeout(pfTimeout)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a, input int i, input logic [31:0] salt);
    return {a[15:0], 16'(i)} ^ salt;
  endfunction

  task automatic sendReq(input logic [31:0] a, input logic [3:0] l, input logic [2:0] t, input logic [2:0] m);
    reqAddr = a; reqLen = l; reqType = t; reqMid = m; reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
  endtask

  task automatic serveFetch(input logic [31:0] a, input int l, input logic [31:0] salt);
    chk(fetchReq == 1'b1, "R2 fetchReq", fetchReq, 1);
    chk(fetchAddr == a && fetchLen == 4'(l), "R2 fetch fields", fetchAddr, a);
    fetchAck = 1'b1; tick(); fetchAck = 1'b0;
    for (int i = 0; i <= l; i++) begin
      secData = pat(a, i, salt); secDataValid = 1'b1; tick();
    end
    secDataValid = 1'b0;
  endtask

  task automatic drainCheck(input logic [31:0] a, input int l, input logic [31:0] salt, input string req);
    int bad = 0;
    chk(respAccept == 1'b1 && respRetry == 1'b0, {req, " accept"}, respAccept, 1);
    for (int i = 0; i <= l; i++) begin
      if (!rdValid || rdData !== pat(a, i, salt) || rdLast !== (i == l)) begin
        bad++;
        $display("FAIL %s beat %0d: actual %0h expected %0h", req, i, rdData, pat(a, i, salt));
      end
      tick();
    end
    checks++; if (bad != 0) errors++;
    chk(rdValid == 1'b0 && fetchReq == 1'b0, {req, " back to idle"}, rdValid, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk({fetchReq, respRetry, respAccept, rdValid, rdLast, pfTimeout} == 6'b0, "R1 reset outputs",
        {fetchReq, respRetry, respAccept, rdValid, rdLast, pfTimeout}, 0);
  endtask

  task automatic t_basic();
    sendReq(32'h1000, 4'd3, 3'd0, 3'd1);
    chk(respRetry == 1'b1 && respAccept == 1'b0, "R2 first read retried", respRetry, 1);
    sendReq(32'h1000, 4'd3, 3'd0, 3'd1);
    chk(respRetry == 1'b1, "R3 identical read during fill retried", respRetry, 1);
    serveFetch(32'h1000, 3, 32'h0);
    sendReq(32'h1000, 4'd3, 3'd0, 3'd1);
    drainCheck(32'h1000, 3, 32'h0, "R6 R3 basic drain");
  endtask

  task automatic t_mismatch();
    sendReq(32'h2040, 4'd1, 3'd2, 3'd5);
    serveFetch(32'h2040, 1, 32'h5A5A0000);
    sendReq(32'h2044, 4'd1, 3'd2, 3'd5);
    chk(respRetry == 1'b1, "R5 address differs", respRetry, 1);
    sendReq(32'h2040, 4'd2, 3'd2, 3'd5);
    chk(respRetry == 1'b1, "R5 length differs", respRetry, 1);
    sendReq(32'h2040, 4'd1, 3'd3, 3'd5);
    chk(respRetry == 1'b1, "R5 type differs", respRetry, 1);
    sendReq(32'h2040, 4'd1, 3'd2, 3'd4);
    chk(respRetry == 1'b1 && fetchReq == 1'b0, "R4 other master, no second fetch", fetchReq, 0);
    sendReq(32'h2040, 4'd1, 3'd2, 3'd5);
    drainCheck(32'h2040, 1, 32'h5A5A0000, "R6 drain after mismatches");
  endtask

  task automatic t_full();
    sendReq(32'h3000, 4'd15, 3'd1, 3'd0);
    serveFetch(32'h3000, 15, 32'h00C30000);
    sendReq(32'h3000, 4'd15, 3'd1, 3'd0);
    drainCheck(32'h3000, 15, 32'h00C30000, "R9 sixteen-word burst");
  endtask

  task automatic t_timeout();
    int early = 0;
    sendReq(32'h4000, 4'd0, 3'd0, 3'd2);
    cyc = 0;
    serveFetch(32'h4000, 0, 32'h11110000);
    while (cyc < 64) begin
      if (pfTimeout) early++;
      tick();
    end
    chk(early == 0, "R7 no early timeout", early, 0);
    chk(pfTimeout == 1'b1, "R7 timeout at 2^TMO_W edges", pfTimeout, 1);
    tick();
    chk(pfTimeout == 1'b0, "R7 timeout one cycle", pfTimeout, 0);
    sendReq(32'h4000, 4'd0, 3'd0, 3'd2);
    chk(respRetry == 1'b1 && fetchReq == 1'b1, "R7 data dropped, new fetch", {respRetry, fetchReq}, 3);
    serveFetch(32'h4000, 0, 32'h22220000);
    sendReq(32'h4000, 4'd0, 3'd0, 3'd2);
    drainCheck(32'h4000, 0, 32'h22220000, "R7 refetched data");
  endtask

  task automatic t_secrst();
    sendReq(32'h5000, 4'd3, 3'd0, 3'd3);
    fetchAck = 1'b1; tick(); fetchAck = 1'b0;
    secData = 32'hDEADBEEF; secDataValid = 1'b1; tick(); secDataValid = 1'b0;
    secRst = 1'b1; tick(); secRst = 1'b0;
    chk(fetchReq == 1'b0 && rdValid == 1'b0, "R8 idle after secondary reset", fetchReq, 0);
    sendReq(32'h5000, 4'd3, 3'd0, 3'd3);
    chk(respRetry == 1'b1, "R8 retried read restarts", respRetry, 1);
    serveFetch(32'h5000, 3, 32'h33330000);
    sendReq(32'h5000, 4'd3, 3'd0, 3'd3);
    drainCheck(32'h5000, 3, 32'h33330000, "R8 only new data returned");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_basic();
    t_mismatch();
    t_full();
    t_timeout();
    t_secrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule